// File: doc/BRIEF.md
# Timing-Error-Detecting Pipeline Register

This block is a chain of pipeline register stages for a datapath run at a supply voltage below its worst-case safe point, where a combinational result can occasionally arrive after the clock edge. Every bit of every stage has two copies. The main flip-flop samples on the normal clock. A shadow element samples the same input on a delayed clock (`clk_dly`, an input to the block). Once a stage holds valid work, a stage-wide OR of the per-bit mismatches marks that stage as late.

The combinational logic between stages lies outside the block: stage k takes its input from its own slice of `stg_d` and shows its content on `stg_q`. A valid bit travels with the data. On a detected error, the stage reloads its main register from the shadow copy at the next clock edge and sends an empty slot (a bubble) to the stage after it. All stages before it are invalidated. A small controller reports the event for one cycle through `recover`, `flush_id` and `bubble_at`. The upstream issue logic must replay any work that entered stage `flush_id` or an earlier stage at that edge. A final stabilising register, with no error checking, commits only values from the last stage that were checked. Stage 0 is the entry stage. A higher index holds older work.

Top module: `tedp_pipe`

## Requirements
- R1: With no error, at each rising clock edge, stage k captures its `stg_d` slice into `stg_q` and takes a valid bit from stage k-1. Stage 0 takes its valid bit from `in_valid`.
- R2: A stage is in error when, just before a rising edge, it is valid, it was not restored at the previous edge, and its main value differs from its shadow value. The shadow value is the stage input sampled at the rising edge of `clk_dly` that follows the previous clock edge. For the cycle after that edge, bit k of `err_stages` is 1 exactly for the stages in error.
- R3: At that edge, the oldest stage in error (call it stage F) loads its shadow value into `stg_q` and stays valid.
- R4: For one cycle after the error edge, `bubble_at` is one-hot with bit F+1 set, and the position it marks is not valid. That position is stage F+1, or the commit register when F is the last stage.
- R5: `recover` is 1 for exactly the cycle after each edge at which some stage is in error, and `flush_id` then equals F.
- R6: When several stages are in error at the same edge, F is the highest-indexed one.
- R7: Every stage with an index below F becomes invalid at the error edge. Every stage with an index above F+1 advances as in R1.
- R8: At each edge, `commit_vld` becomes the valid bit of the last stage, gated off when that stage is in error. `commit_data` then takes the last stage's value.
- R9: A mismatch in a stage that is not valid, or in a stage restored at the previous edge, raises no error.
- R10: While `rst` is high at a rising edge, all stage valid bits, `err_stages`, `recover`, `bubble_at` and `commit_vld` are cleared at that edge.
- R11: At the edge after a restore, the restored value moves on as valid work into stage F+1, or into the commit register when F is the last stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Normal clock |
| clk_dly | input | 1 | Delayed copy of clk for the shadow samples |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Valid bit entering stage 0 |
| stg_d | input | STAGES*W | Stage inputs, stage k at bits k*W +: W |
| stg_q | output | STAGES*W | Stage contents, same layout |
| stg_vld | output | STAGES | Per-stage valid bits |
| commit_vld | output | 1 | Stabilised commit is valid |
| commit_data | output | W | Stabilised commit value |
| recover | output | 1 | One-cycle recovery pulse |
| flush_id | output | IDW | Index of the oldest stage in error |
| bubble_at | output | STAGES+1 | One-hot bubble position, top bit is the commit register |
| err_stages | output | STAGES | Registered per-stage error flags |

## Verification
The hardest situation to reach is a new mismatch arriving in the cycle right after a restore, at the same time as errors in other stages, because it needs late data on several stages in consecutive cycles while the valid pattern is just so. The bench creates late arrival by driving a wrong value before the clock edge and the true value after it, ahead of the delayed edge. It sweeps every injection mask against every pattern of three entry valid bits, with follow-up cycles. A cycle model built from the requirements predicts every output at each edge.

// File: rtl/tedp_pkg.sv
package tedp_pkg;

    typedef enum logic [1:0] {
        ST_SHIFT   = 2'd0,
        ST_RESTORE = 2'd1,
        ST_KILL    = 2'd2
    } stage_op_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic logic [31:0] below_mask(input int idx);
        return (32'd1 << idx) - 32'd1;
    endfunction

endpackage

// File: rtl/tedp_bit_cell.sv
module tedp_bit_cell (
    input  logic clk,
    input  logic clk_dly,
    input  logic d,
    input  logic restore,
    output logic q,
    output logic sh,
    output logic mism
);
    // main sample on the normal clock, reloaded from the shadow on restore
    always_ff @(posedge clk) begin
        q <= restore ? sh : d;
    end

    // late sample of the same input on the delayed clock
    always_ff @(posedge clk_dly) begin
        sh <= d;
    end

    assign mism = q ^ sh;
endmodule

// File: rtl/tedp_stage.sv
module tedp_stage #(
    parameter int W = 16
) (
    input  logic                 clk,
    input  logic                 clk_dly,
    input  logic                 rst,
    input  logic [W-1:0]         d,
    input  logic                 vld_in,
    input  tedp_pkg::stage_op_e  op,
    output logic [W-1:0]         q,
    output logic                 vld,
    output logic                 err
);
    import tedp_pkg::*;

    logic [W-1:0] sh;
    logic [W-1:0] mism;
    logic         hold;
    logic         restore;

    assign restore = (op == ST_RESTORE);

    for (genvar b = 0; b < W; b++) begin : g_bit
        tedp_bit_cell u_cell (
            .clk     (clk),
            .clk_dly (clk_dly),
            .d       (d[b]),
            .restore (restore),
            .q       (q[b]),
            .sh      (sh[b]),
            .mism    (mism[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld  <= 1'b0;
            hold <= 1'b0;
        end else begin
            case (op)
                ST_RESTORE: begin
                    vld  <= 1'b1;
                    hold <= 1'b1;
                end
                ST_KILL: begin
                    vld  <= 1'b0;
                    hold <= 1'b0;
                end
                default: begin
                    vld  <= vld_in;
                    hold <= 1'b0;
                end
            endcase
        end
    end

    // stage-wide OR of the bit mismatches, masked when empty or just restored
    assign err = vld & ~hold & (|mism);

    a_r3_restore_from_shadow: assert property (@(posedge clk) disable iff (rst)
        restore |=> (vld && q == $past(sh)));

    a_r9_no_err_after_restore: assert property (@(posedge clk) disable iff (rst)
        restore |=> !err);
endmodule

// File: rtl/tedp_flush_ctrl.sv
module tedp_flush_ctrl #(
    parameter int STAGES = 4,
    parameter int IDW    = 2
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [STAGES-1:0]                   err,
    output tedp_pkg::stage_op_e [STAGES-1:0]    op,
    output logic                                recover,
    output logic [IDW-1:0]                      flush_id,
    output logic [STAGES:0]                     bubble_at,
    output logic [STAGES-1:0]                   err_stages
);
    import tedp_pkg::*;

    logic           any;
    logic [IDW-1:0] oldest;

    // highest index wins: later iterations overwrite earlier ones
    always_comb begin
        any    = 1'b0;
        oldest = '0;
        for (int k = 0; k < STAGES; k++) begin
            if (err[k]) begin
                any    = 1'b1;
                oldest = IDW'(k);
            end
        end
    end

    always_comb begin
        for (int k = 0; k < STAGES; k++) begin
            if (any && (k == int'(oldest)))
                op[k] = ST_RESTORE;
            else if (any && (k < int'(oldest)))
                op[k] = ST_KILL;
            else
                op[k] = ST_SHIFT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            recover    <= 1'b0;
            flush_id   <= '0;
            bubble_at  <= '0;
            err_stages <= '0;
        end else begin
            recover    <= any;
            flush_id   <= oldest;
            bubble_at  <= any ? ((STAGES+1)'(1) << (int'(oldest) + 1)) : '0;
            err_stages <= err;
        end
    end

    a_r6_oldest_reported: assert property (@(posedge clk) disable iff (rst)
        recover |-> ((err_stages >> flush_id) == STAGES'(1)));
endmodule

// File: rtl/tedp_pipe.sv
module tedp_pipe #(
    parameter int W      = 16,
    parameter int STAGES = 4,
    localparam int IDW   = tedp_pkg::idx_width(STAGES)
) (
    input  logic                  clk,
    input  logic                  clk_dly,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [STAGES*W-1:0]   stg_d,
    output logic [STAGES*W-1:0]   stg_q,
    output logic [STAGES-1:0]     stg_vld,
    output logic                  commit_vld,
    output logic [W-1:0]          commit_data,
    output logic                  recover,
    output logic [IDW-1:0]        flush_id,
    output logic [STAGES:0]       bubble_at,
    output logic [STAGES-1:0]     err_stages
);
    import tedp_pkg::*;

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0]            err;
    logic [STAGES-1:0]            vld_in;
    stage_op_e [STAGES-1:0]       op;
    logic [W-1:0]                 q_arr [STAGES];

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_head
            assign vld_in[k] = in_valid;
        end else begin : g_body
            // a stage in error passes a bubble to the next one
            assign vld_in[k] = stg_vld[k-1] & ~err[k-1];
        end

        tedp_stage #(.W(W)) u_stage (
            .clk     (clk),
            .clk_dly (clk_dly),
            .rst     (rst),
            .d       (stg_d[k*W +: W]),
            .vld_in  (vld_in[k]),
            .op      (op[k]),
            .q       (q_arr[k]),
            .vld     (stg_vld[k]),
            .err     (err[k])
        );

        assign stg_q[k*W +: W] = q_arr[k];
    end

    tedp_flush_ctrl #(.STAGES(STAGES), .IDW(IDW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .err        (err),
        .op         (op),
        .recover    (recover),
        .flush_id   (flush_id),
        .bubble_at  (bubble_at),
        .err_stages (err_stages)
    );

    // stabilising commit register: no shadow, only checked values pass
    always_ff @(posedge clk) begin
        if (rst) begin
            commit_vld <= 1'b0;
        end else begin
            commit_vld <= stg_vld[LAST] & ~err[LAST];
        end
    end

    always_ff @(posedge clk) begin
        if (stg_vld[LAST] & ~err[LAST])
            commit_data <= q_arr[LAST];
    end

    logic [STAGES-1:0] younger_m;
    assign younger_m = STAGES'(below_mask(int'(flush_id)));

    a_r4_bubble_slot: assert property (@(posedge clk) disable iff (rst)
        recover |-> ($countones(bubble_at) == 1 &&
                     (bubble_at[STAGES] ? !commit_vld
                                        : ((stg_vld & bubble_at[STAGES-1:0]) == '0))));

    a_r5_flushed_stage_valid: assert property (@(posedge clk) disable iff (rst)
        recover |-> ((stg_vld >> flush_id) & STAGES'(1)) == STAGES'(1));

    a_r7_younger_flushed: assert property (@(posedge clk) disable iff (rst)
        recover |-> ((stg_vld & younger_m) == '0));

    a_r8_commit_checked: assert property (@(posedge clk) disable iff (rst)
        commit_vld |-> ($past(stg_vld[LAST]) && commit_data == $past(q_arr[LAST])));

    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (stg_vld == '0 && !recover && !commit_vld && bubble_at == '0));
endmodule

// File: tb/sim_tedp_pipe.sv
module sim_tedp_pipe;
    localparam int W   = 8;
    localparam int S   = 3;
    localparam int IDW = 2;
    localparam int L   = S - 1;

    logic             clk, clk_dly, rst, in_valid;
    logic [S*W-1:0]   stg_d, stg_q;
    logic [S-1:0]     stg_vld, err_stages;
    logic             commit_vld, recover;
    logic [W-1:0]     commit_data;
    logic [IDW-1:0]   flush_id;
    logic [S:0]       bubble_at;

    tedp_pipe #(.W(W), .STAGES(S)) u0 (
        .clk(clk), .clk_dly(clk_dly), .rst(rst), .in_valid(in_valid),
        .stg_d(stg_d), .stg_q(stg_q), .stg_vld(stg_vld),
        .commit_vld(commit_vld), .commit_data(commit_data),
        .recover(recover), .flush_id(flush_id), .bubble_at(bubble_at),
        .err_stages(err_stages)
    );

    initial begin clk = 0; forever #10 clk = ~clk; end
    initial begin clk_dly = 0; #5; forever #10 clk_dly = ~clk_dly; end

    int nchk = 0, nfail = 0;
    logic [15:0] lfsr = 16'hACE1;

    // reference state
    logic [W-1:0] mq [S];
    logic [W-1:0] msh [S];
    logic [S-1:0] mvld = '0, mhold = '0;
    logic [W-1:0] mcd = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic iv, input logic [S-1:0] inj);
        logic [W-1:0] tv [S];
        logic [W-1:0] ev [S];
        logic [W-1:0] nq [S];
        logic [S-1:0] er, nv, nh;
        logic any, cv;
        int old, nerr;
        logic [S:0] bub;
        @(negedge clk);
        rst = r; in_valid = iv;
        for (int k = 0; k < S; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tv[k] = lfsr[W-1:0];
            ev[k] = inj[k] ? ~lfsr[W-1:0] : lfsr[W-1:0];
            stg_d[k*W +: W] = ev[k];
        end
        any = 0; old = 0; nerr = 0;
        for (int k = 0; k < S; k++) begin
            er[k] = mvld[k] & ~mhold[k] & (mq[k] != msh[k]);
            if (er[k]) begin any = 1; old = k; nerr++; end
        end
        for (int k = 0; k < S; k++) begin
            nq[k] = ev[k]; nh[k] = 0;
            if (any && k == old) begin nq[k] = msh[k]; nv[k] = 1; nh[k] = 1; end
            else if (any && k < old) nv[k] = 0;
            else nv[k] = (k == 0) ? iv : (mvld[k-1] & ~er[k-1]);
        end
        cv  = mvld[L] & ~er[L];
        bub = any ? ((S+1)'(1) << (old + 1)) : '0;
        @(posedge clk); #2;
        for (int k = 0; k < S; k++) stg_d[k*W +: W] = tv[k];
        #6;
        if (r) begin
            chk("R10 valid", 32'(stg_vld), 0);
            chk("R10 recover", 32'(recover), 0);
            chk("R10 bubble", 32'(bubble_at), 0);
            chk("R10 errflags", 32'(err_stages), 0);
            chk("R10 commit", 32'(commit_vld), 0);
            mvld = '0; mhold = '0;
        end else begin
            for (int k = 0; k < S; k++) begin
                if (any && k < old)          chk("R7 flushed", 32'(stg_vld[k]), 32'(nv[k]));
                else if (any && k == old+1)  chk("R4 bubble valid", 32'(stg_vld[k]), 32'(nv[k]));
                else if (k > 0 && mhold[k-1]) chk("R11 forward", 32'(stg_vld[k]), 32'(nv[k]));
                else                         chk("R1 valid", 32'(stg_vld[k]), 32'(nv[k]));
                if (nv[k]) begin
                    if (nh[k]) chk("R3 restored", 32'(stg_q[k*W +: W]), 32'(nq[k]));
                    else       chk("R1 data", 32'(stg_q[k*W +: W]), 32'(nq[k]));
                end
            end
            chk(mhold[L] ? "R11 commit valid" : "R8 commit valid", 32'(commit_vld), 32'(cv));
            if (cv) begin
                mcd = mq[L];
                chk("R8 commit data", 32'(commit_data), 32'(mcd));
            end
            chk("R5 recover", 32'(recover), 32'(any));
            if (any) chk(nerr > 1 ? "R6 priority" : "R5 flush id", 32'(flush_id), 32'(old));
            chk("R4 bubble", 32'(bubble_at), 32'(bub));
            chk(((mvld & ~mhold) != (mvld | mhold)) ? "R9 masked" : "R2 errflags",
                32'(err_stages), 32'(er));
            mvld = nv; mhold = nh;
        end
        for (int k = 0; k < S; k++) begin mq[k] = nq[k]; msh[k] = tv[k]; end
    endtask

    initial begin
        rst = 1; in_valid = 0; stg_d = '0;
        for (int i = 0; i < 3; i++) step(1, 0, '0);
        // directed: fill, single error in middle stage, then two at once
        for (int i = 0; i < 3; i++) step(0, 1, '0);
        step(0, 1, 3'b010);
        for (int i = 0; i < 3; i++) step(0, 1, '0);
        step(0, 1, 3'b101);
        for (int i = 0; i < 3; i++) step(0, 1, '0);
        // sweep injection masks against entry valid patterns
        for (int m = 0; m < 8; m++) begin
            for (int v = 0; v < 8; v++) begin
                for (int i = 0; i < 3; i++) step(0, v[i], '0);
                step(0, 1, S'(m));
                step(0, v[0], S'(m ^ 7));
                step(0, 1, S'(m));
                step(0, 0, '0);
            end
        end
        step(1, 1, 3'b111);
        step(1, 0, '0);
        step(0, 1, '0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #4000000;
        nchk++; nfail++;
        $display("FAIL R1 watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule